// File: doc/BRIEF.md
# Phase-Offset Sine Amplitude Stage

This stage sits behind a numerically controlled oscillator. Each clock it takes the oscillator's 8-bit quantized phase, adds a programmable 8-bit phase offset, and turns the resulting angle into an 8-bit sine amplitude. Alongside the amplitude it produces single-bit square-wave sine and cosine outputs that carry the same offset. The offset is the phase-shift-keying control: a value of 128 turns the carrier half a cycle, a value of 0 leaves it unchanged.

Software or a modulator writes the offset through a parallel data bus and an active-low write strobe. The strobe does not need to be related to the system clock. The data is captured when the strobe goes high again. A two-stage synchronizer and an edge detector then move the captured value into the clock domain as one load pulse. The amplitude path stores only the first quarter of a sine period. The other three quarters come from mirroring the table address and inverting the magnitude.

Top module: `psk_sine_core`

## Requirements
- R1: While reset is asserted, `amp_o`, `msin_o` and `mcos_o` are all 0. Reset also clears the applied offset to 0.
- R2: The offset word is captured on the rising edge of `ofs_wr_n_i` and takes effect on the outputs within 8 clock cycles. Holding the strobe low leaves the applied offset unchanged. Changing `ofs_word_i` while the strobe is low leaves the applied offset unchanged.
- R3: Once the strobe is high, later changes of `ofs_word_i` have no effect. One release of the strobe causes exactly one load.
- R4: The modulated phase p is (acc + offset) mod 256, where an offset of k means k·2π/256 rad. The outputs reflect the `acc_phase_i` value that was present two rising clock edges earlier.
- R5: The stored magnitude for address a (0..63) is round(127·sin((2a+1)·π/256)).
- R6: When p[6] is 1 (second and fourth quadrants), the table address is the bitwise inverse of p[5:0]. Otherwise the address is p[5:0].
- R7: `amp_o[7]` equals p[7]. `amp_o[6:0]` is the magnitude when p[7] is 0 and its bitwise inverse when p[7] is 1. Read as two's complement, this gives +m or −(m+1).
- R8: `msin_o` equals p[7]. `mcos_o` equals p[7] XOR p[6].
- R9: For a given accumulator phase, an offset of 128 inverts `msin_o` and `amp_o[7]` compared with an offset of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_phase_i | input | 8 | Quantized phase from the oscillator accumulator |
| ofs_word_i | input | 8 | Phase offset data word |
| ofs_wr_n_i | input | 1 | Active-low offset write strobe, asynchronous to clk |
| amp_o | output | 8 | Sine amplitude |
| msin_o | output | 1 | Square sine with offset applied |
| mcos_o | output | 1 | Square cosine with offset applied |

## Verification
The checks assume that `ofs_word_i` is stable around the rising edge of the strobe. They also assume that each level of the strobe lasts longer than two clock cycles, so the synchronizer sees every low and every high phase. The stimulus changes the data only while the strobe is low or long after a release. It holds each strobe level for at least three cycles. It waits out the synchronizer latency before it expects a new offset on the outputs. The accumulator phase is driven one value per cycle and is never held across a gap the pipeline cannot see.

// File: rtl/psk_sine_pkg.sv
`timescale 1ns/1ps
package psk_sine_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Quarter-wave magnitude, sampled at the middle of each address step.
  function automatic int qsine_mag(input int idx, input int addr_w, input int mag_w);
    real full_scale;
    real angle;
    full_scale = real'((1 << mag_w) - 1);
    angle = (2.0 * real'(idx) + 1.0) * PI_R / real'(1 << (addr_w + 2));
    return $rtoi(full_scale * $sin(angle) + 0.5);
  endfunction

endpackage

// File: rtl/psk_ofs_loader.sv
`timescale 1ns/1ps
module psk_ofs_loader #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arst_n,
  input  logic [PH_W-1:0] word_i,
  input  logic            wr_n_i,
  output logic [PH_W-1:0] ofs_q,
  output logic            load_p
);

  logic [PH_W-1:0] cap_q;
  logic            meta_q, sync_q, dly_q;
  logic [PH_W-1:0] ofs_d;

  // capture in the strobe domain on its release
  always_ff @(posedge wr_n_i or negedge arst_n) begin
    if (!arst_n) cap_q <= '0;
    else         cap_q <= word_i;
  end

  // idle strobe level is high, so reset the chain high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      dly_q  <= 1'b1;
    end else begin
      meta_q <= wr_n_i;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  always_comb begin
    load_p = sync_q & ~dly_q;
    ofs_d  = ofs_q;
    if (load_p) ofs_d = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ofs_q <= '0;
    else        ofs_q <= ofs_d;
  end

endmodule

// File: rtl/psk_phase_add.sv
`timescale 1ns/1ps
module psk_phase_add #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] acc_i,
  input  logic [PH_W-1:0] ofs_i,
  output logic [PH_W-1:0] mod_q
);

  logic [PH_W-1:0] mod_d;

  always_comb mod_d = acc_i + ofs_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_q <= '0;
    else        mod_q <= mod_d;
  end

endmodule

// File: rtl/psk_qsine_lut.sv
`timescale 1ns/1ps
module psk_qsine_lut
  import psk_sine_pkg::*;
#(
  parameter int PH_W  = 8,
  parameter int MAG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   ph_i,
  output logic [MAG_W:0]    amp_q,
  output logic              sin_q,
  output logic              cos_q
);

  localparam int ADDR_W = PH_W - 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [MAG_W-1:0]  tbl [DEPTH];
  logic [ADDR_W-1:0] addr;
  logic [MAG_W-1:0]  mag;
  logic              half_neg, mirror;
  logic [MAG_W:0]    amp_d;
  logic              sin_d, cos_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    localparam int VAL = qsine_mag(g, ADDR_W, MAG_W);
    assign tbl[g] = MAG_W'(VAL);
  end

  always_comb begin
    half_neg = ph_i[PH_W-1];
    mirror   = ph_i[PH_W-2];
    addr     = mirror ? ~ph_i[ADDR_W-1:0] : ph_i[ADDR_W-1:0];
    mag      = tbl[addr];
    amp_d    = {half_neg, (half_neg ? ~mag : mag)};
    sin_d    = half_neg;
    cos_d    = half_neg ^ mirror;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q <= '0;
      sin_q <= 1'b0;
      cos_q <= 1'b0;
    end else begin
      amp_q <= amp_d;
      sin_q <= sin_d;
      cos_q <= cos_d;
    end
  end

endmodule

// File: rtl/psk_sine_core.sv
`timescale 1ns/1ps
module psk_sine_core #(
  parameter int PH_W  = 8,
  parameter int MAG_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      acc_phase_i,
  input  logic [7:0]      ofs_word_i,
  input  logic            ofs_wr_n_i,
  output logic [7:0]      amp_o,
  output logic            msin_o,
  output logic            mcos_o
);

  logic            rst_m_q, rst_sync_n;
  logic [PH_W-1:0] ofs_q;
  logic            load_p;
  logic [PH_W-1:0] mod_ph;
  logic [MAG_W:0]  amp_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_m_q} <= 2'b00;
    else        {rst_sync_n, rst_m_q} <= {rst_m_q, 1'b1};
  end

  psk_ofs_loader #(.PH_W(PH_W)) u_load (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .arst_n (rst_n),
    .word_i (PH_W'(ofs_word_i)),
    .wr_n_i (ofs_wr_n_i),
    .ofs_q  (ofs_q),
    .load_p (load_p)
  );

  psk_phase_add #(.PH_W(PH_W)) u_add (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .acc_i (PH_W'(acc_phase_i)),
    .ofs_i (ofs_q),
    .mod_q (mod_ph)
  );

  psk_qsine_lut #(.PH_W(PH_W), .MAG_W(MAG_W)) u_lut (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ph_i  (mod_ph),
    .amp_q (amp_w),
    .sin_q (msin_o),
    .cos_q (mcos_o)
  );

  assign amp_o = 8'(amp_w);

endmodule

// File: rtl/psk_sine_core_chk.sv
`timescale 1ns/1ps
module psk_sine_core_chk #(
  parameter int PH_W  = 8,
  parameter int MAG_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      acc_phase,
  input logic [PH_W-1:0] ofs_q,
  input logic            load_p,
  input logic [PH_W-1:0] mod_ph,
  input logic [7:0]      amp,
  input logic            msin,
  input logic            mcos
);

  logic pv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= 1'b1;
  end

  // R2: offset register moves only on a load pulse
  a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_p |=> $stable(ofs_q));

  // R3: one release gives a single-cycle load pulse
  a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |=> !load_p);

  // R4: registered modular sum of accumulator and offset
  a_r4_mod_sum: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> mod_ph == $past(PH_W'(PH_W'(acc_phase) + ofs_q)));

  // R7: amplitude sign bit follows the half-cycle bit
  a_r7_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> amp[7] == $past(mod_ph[PH_W-1]));

  // R8: square outputs follow the top phase bits
  a_r8_square_out: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> (msin == $past(mod_ph[PH_W-1])) &&
             (mcos == $past(mod_ph[PH_W-1] ^ mod_ph[PH_W-2])));

endmodule

bind psk_sine_core psk_sine_core_chk #(.PH_W(PH_W), .MAG_W(MAG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_phase (acc_phase_i),
  .ofs_q     (ofs_q),
  .load_p    (load_p),
  .mod_ph    (mod_ph),
  .amp       (amp_o),
  .msin      (msin_o),
  .mcos      (mcos_o)
);

// File: tb/psk_sine_core_tb.sv
`timescale 1ns/1ps
module psk_sine_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_phase_i = '0;
  logic [7:0] ofs_word_i = '0;
  logic       ofs_wr_n_i = 1'b1;
  logic [7:0] amp_o;
  logic       msin_o, mcos_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model_ofs = '0;

  typedef struct {
    bit         chk;
    logic [7:0] amp;
    logic       s;
    logic       c;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  psk_sine_core dut_i (
    .clk(clk), .rst_n(rst_n), .acc_phase_i(acc_phase_i),
    .ofs_word_i(ofs_word_i), .ofs_wr_n_i(ofs_wr_n_i),
    .amp_o(amp_o), .msin_o(msin_o), .mcos_o(mcos_o)
  );

  // reference amplitude from R5/R6/R7
  function automatic logic [7:0] ref_amp(input logic [7:0] p);
    int a;
    int m;
    logic [6:0] m7;
    a  = p[6] ? (63 - int'(p[5:0])) : int'(p[5:0]);
    m  = $rtoi(127.0 * $sin((2.0 * real'(a) + 1.0) * 3.14159265358979 / 256.0) + 0.5);
    m7 = 7'(m);
    return p[7] ? {1'b1, ~m7} : {1'b0, m7};
  endfunction

  // driver: one accumulator value per cycle, expectation queued
  task automatic step(input logic [7:0] acc, input bit chk, input string tag);
    exp_t e;
    logic [7:0] p;
    @(posedge clk);
    #1;
    acc_phase_i = acc;
    p = acc + model_ofs;
    e.chk = chk;
    e.amp = ref_amp(p);
    e.s   = p[7];
    e.c   = p[7] ^ p[6];
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'd0, 1'b0, "");
  endtask

  // monitor: outputs lag the driven value by two edges
  always @(negedge clk) begin
    if (q.size() >= 3) begin
      exp_t g;
      g = q.pop_front();
      if (g.chk) begin
        checks++;
        if (amp_o !== g.amp || msin_o !== g.s || mcos_o !== g.c) begin
          failures++;
          $display("FAIL %s: amp=%0d sin=%0b cos=%0b expected amp=%0d sin=%0b cos=%0b",
                   g.tag, amp_o, msin_o, mcos_o, g.amp, g.s, g.c);
        end
      end
    end
  end

  task automatic write_ofs(input logic [7:0] w);
    ofs_word_i = w;
    ofs_wr_n_i = 1'b0;
    idle(4);
    ofs_wr_n_i = 1'b1;
    idle(8);
    model_ofs = w;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: outputs held at zero during reset
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      checks++;
      if (amp_o !== 8'd0 || msin_o !== 1'b0 || mcos_o !== 1'b0) begin
        failures++;
        $display("FAIL R1: amp=%0d sin=%0b cos=%0b expected 0 0 0", amp_o, msin_o, mcos_o);
      end
      @(negedge clk);
    end
    rst_n = 1'b1;
    idle(4);

    // R1 R4 R5 R6 R7 R8: full sweep with the reset offset of zero
    for (int i = 0; i < 256; i++) step(8'(i), 1'b1, "R1 R4 R5 R6 R7 R8 zero offset");

    // R2 R4: offset 37, sweep wraps modulo 256
    write_ofs(8'd37);
    for (int i = 0; i < 256; i++) step(8'(255 - i), 1'b1, "R2 R4 offset 37");

    // R2: strobe held low, data changed, no effect yet
    ofs_word_i = 8'd99;
    ofs_wr_n_i = 1'b0;
    for (int i = 0; i < 12; i++) step(8'(i * 21), 1'b1, "R2 strobe low");
    ofs_word_i = 8'd200;
    for (int i = 0; i < 8; i++) step(8'(i * 33 + 7), 1'b1, "R2 data change while low");
    ofs_wr_n_i = 1'b1;
    idle(8);
    model_ofs = 8'd200;
    for (int i = 0; i < 16; i++) step(8'(i * 16 + 3), 1'b1, "R2 new offset 200");

    // R3: data changes after release are ignored
    ofs_word_i = 8'd5;
    for (int i = 0; i < 16; i++) step(8'(i * 17), 1'b1, "R3 data change after release");
    ofs_word_i = 8'd77;
    for (int i = 0; i < 8; i++) step(8'(i * 31), 1'b1, "R3 second data change");

    // R9: binary PSK, offset 0 then 128
    write_ofs(8'd0);
    for (int i = 0; i < 16; i++) step(8'(i * 16 + 5), 1'b1, "R9 bit one offset 0");
    write_ofs(8'd128);
    for (int i = 0; i < 16; i++) step(8'(i * 16 + 5), 1'b1, "R9 bit zero offset 128");

    idle(4);
    finish_run();
  end

endmodule